// File: doc/BRIEF.md
# Seven-to-one serial link transmitter

This block turns a wide parallel word stream into a set of serial lanes for a multi-lane camera output link. One fast bit clock drives everything. A modulo-7 phase counter splits the bit clock into word periods. Each data lane loads a 7-bit word once per period and sends it out one bit per bit clock, most significant bit first. The lanes are arranged in channel groups. Each group has several data lanes and one forwarded clock lane. The forwarded clock runs at the word rate and is built from the same phase counter, so its phase to the data is fixed.

A one-cycle strobe tells upstream logic when its parallel word is taken. Every serial output and every forwarded clock output comes straight from a flip-flop in the bit-clock domain. No logic sits between those flip-flops and the pins, so all lanes launch with the same clock-to-output timing. The differential pad buffers and the clock synthesis are outside this block.

Top module: `sevenfold_link_tx`

## Requirements
- R1: The internal phase advances 0,1,...,6 and then wraps to 0, so `load_o` pulses exactly once every 7 bit clocks.
- R2: `load_o` is high for one cycle, the cycle at phase 6. The block samples `word_i` on the rising edge that ends that cycle.
- R3: Every forwarded clock output is high at phases 0, 4, 5 and 6 and low at phases 1, 2 and 3. In the cycles after a `load_o` cycle it therefore reads 1,0,0,0,1,1,1.
- R4: In the 7 cycles after a `load_o` cycle, data lane L shows the word it sampled, bit 6 first and bit 0 last, one bit per cycle.
- R5: Lane L (group g, lane k, L = g*4+k) takes its word from `word_i[L*7 +: 7]`. The lanes are independent of each other, and all forwarded clock outputs are equal at all times.
- R6: A change on `word_i` in any cycle other than the `load_o` cycle has no effect on any serial output.
- R7: While `rst` is sampled high, the outputs show, from the next cycle on, all data lanes 0, all forwarded clocks 1 and `load_o` 0. The phase restarts at 0. The first `load_o` after reset comes 6 cycles after the first cycle with `rst` low at phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the word rate |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | GROUPS*LANES_PER_GROUP*WORD_BITS (84) | Parallel words, lane L at bits L*7+6..L*7 |
| load_o | output | 1 | High in the cycle whose ending edge samples `word_i` |
| ser_o | output | GROUPS*LANES_PER_GROUP (12) | Serial data lanes, one bit each |
| fclk_o | output | GROUPS (3) | Forwarded word-rate clock, one per group |

## Verification
The bench builds the block with its default parameters: three groups of four lanes and 7-bit words. These values cover the real 4-high/3-low clock shape and the full 84-bit word layout. A behavioural model predicts every output on every cycle. Between load cycles the bench puts random values on `word_i`, so every period also tests that off-strobe input changes are ignored. A reset in the middle of a word shows that the phase restarts and that the first strobe comes at the right cycle.

// File: rtl/slk_pkg.sv
package slk_pkg;

  // Level of the forwarded clock at a given phase: high at phase 0 and in
  // the last (high_bits-1) phases of the period, low elsewhere.
  function automatic logic fwd_level(input int ph, input int word_bits, input int high_bits);
    return (ph == 0) || (ph >= word_bits - high_bits + 1);
  endfunction

  // Phase that follows ph in a period of word_bits phases.
  function automatic int phase_after(input int ph, input int word_bits);
    return (ph == word_bits - 1) ? 0 : ph + 1;
  endfunction

endpackage

// File: rtl/slk_phase_gen.sv
module slk_phase_gen #(
  parameter int WORD_BITS = 7,
  localparam int PW = $clog2(WORD_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [PW-1:0] phase,
  output logic [PW-1:0] phase_next,
  output logic          wrap,
  output logic          load_o
);
  import slk_pkg::*;

  localparam logic [PW-1:0] LAST = PW'(WORD_BITS - 1);

  always_comb begin
    phase_next = PW'(phase_after(int'(phase), WORD_BITS));
    wrap       = (phase == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      load_o <= 1'b0;
    end else begin
      phase  <= phase_next;
      load_o <= (phase_next == LAST);
    end
  end
endmodule

// File: rtl/slk_lane.sv
module slk_lane #(
  parameter int WORD_BITS = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic [WORD_BITS-1:0] word,
  output logic                 ser
);
  logic [WORD_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst)       shreg <= '0;
    else if (load) shreg <= word;
    else           shreg <= {shreg[WORD_BITS-2:0], 1'b0};
  end

  // Port driven directly by the top flop of the shift register.
  assign ser = shreg[WORD_BITS-1];
endmodule

// File: rtl/slk_fclk_lane.sv
module slk_fclk_lane #(
  parameter int WORD_BITS = 7,
  parameter int HIGH_BITS = 4,
  localparam int PW = $clog2(WORD_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] phase_next,
  output logic          fclk
);
  import slk_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) fclk <= fwd_level(0, WORD_BITS, HIGH_BITS);
    else     fclk <= fwd_level(int'(phase_next), WORD_BITS, HIGH_BITS);
  end
endmodule

// File: rtl/sevenfold_link_tx.sv
module sevenfold_link_tx #(
  parameter int GROUPS          = 3,
  parameter int LANES_PER_GROUP = 4,
  parameter int WORD_BITS       = 7,
  parameter int HIGH_BITS       = 4,
  localparam int LANES = GROUPS * LANES_PER_GROUP,
  localparam int PW    = $clog2(WORD_BITS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [LANES*WORD_BITS-1:0] word_i,
  output logic                       load_o,
  output logic [LANES-1:0]           ser_o,
  output logic [GROUPS-1:0]          fclk_o
);
  logic [PW-1:0] phase;
  logic [PW-1:0] phase_next;
  logic          wrap;

  slk_phase_gen #(.WORD_BITS(WORD_BITS)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .phase      (phase),
    .phase_next (phase_next),
    .wrap       (wrap),
    .load_o     (load_o)
  );

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    slk_fclk_lane #(.WORD_BITS(WORD_BITS), .HIGH_BITS(HIGH_BITS)) u_fclk (
      .clk        (clk),
      .rst        (rst),
      .phase_next (phase_next),
      .fclk       (fclk_o[g])
    );
    for (genvar k = 0; k < LANES_PER_GROUP; k++) begin : g_lane
      localparam int L = g * LANES_PER_GROUP + k;
      slk_lane #(.WORD_BITS(WORD_BITS)) u_lane (
        .clk  (clk),
        .rst  (rst),
        .load (wrap),
        .word (word_i[L*WORD_BITS +: WORD_BITS]),
        .ser  (ser_o[L])
      );
    end
  end
endmodule

// File: rtl/slk_checker.sv
module slk_checker #(
  parameter int GROUPS          = 3,
  parameter int LANES_PER_GROUP = 4,
  parameter int WORD_BITS       = 7,
  localparam int LANES = GROUPS * LANES_PER_GROUP,
  localparam int PW    = $clog2(WORD_BITS)
) (
  input logic                       clk,
  input logic                       rst,
  input logic [LANES*WORD_BITS-1:0] word_i,
  input logic                       load_o,
  input logic [LANES-1:0]           ser_o,
  input logic [GROUPS-1:0]          fclk_o,
  input logic [PW-1:0]              phase
);
  localparam logic [PW-1:0] LAST = PW'(WORD_BITS - 1);

  logic [LANES-1:0] msb_vec;
  for (genvar l = 0; l < LANES; l++) begin : g_msb
    assign msb_vec[l] = word_i[l*WORD_BITS + WORD_BITS - 1];
  end

  logic prev_rst = 1'b0;
  always_ff @(posedge clk) prev_rst <= rst;

  // R1: phase steps by one and wraps after the last value
  p_phase_step_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phase) != LAST) |-> phase == $past(phase) + PW'(1));
  p_phase_wrap_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(phase) == LAST) |-> phase == '0);

  // R2: strobe marks the last phase and never lasts two cycles
  p_strobe_phase_r2: assert property (@(posedge clk) disable iff (rst)
    load_o |-> phase == LAST);
  p_strobe_single_r2: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o);

  // R3: clock lanes are low in phases 1..3 and high at phase 0
  p_fclk_low_r3: assert property (@(posedge clk) disable iff (rst)
    (phase >= PW'(1) && phase <= PW'(3)) |-> fclk_o == '0);
  p_fclk_high_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == '0) |-> fclk_o == '1);

  // R4, R5: first bit after the strobe is each lane's sampled MSB
  p_first_bit_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(load_o)) |-> ser_o == $past(msb_vec));

  // R5: all forwarded clocks agree
  p_fclk_equal_r5: assert property (@(posedge clk) disable iff (rst)
    fclk_o == '0 || fclk_o == '1);

  // R7: state right after a reset edge
  always_ff @(posedge clk) begin
    if (prev_rst) begin
      a_reset_state_r7: assert (ser_o == '0 && fclk_o == '1 && !load_o && phase == '0);
    end
  end
endmodule

bind sevenfold_link_tx slk_checker #(
  .GROUPS(GROUPS), .LANES_PER_GROUP(LANES_PER_GROUP), .WORD_BITS(WORD_BITS)
) u_chk (
  .clk(clk), .rst(rst), .word_i(word_i), .load_o(load_o),
  .ser_o(ser_o), .fclk_o(fclk_o), .phase(phase)
);

// File: tb/sevenfold_link_tx_test.sv
`timescale 1ns/1ps
module sevenfold_link_tx_test;
  localparam int NL = 12;
  localparam int NG = 3;
  localparam int WB = 7;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NL*WB-1:0] word_i = '0;
  logic            load_o;
  logic [NL-1:0]   ser_o;
  logic [NG-1:0]   fclk_o;

  always #2.5 clk = ~clk;

  sevenfold_link_tx uut (
    .clk(clk), .rst(rst), .word_i(word_i),
    .load_o(load_o), .ser_o(ser_o), .fclk_o(fclk_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase as integer, loaded words per lane.
  int          m_ph = 0;
  bit [WB-1:0] m_word [NL];
  bit          seen_edge = 0;
  int          since_rst = 0;
  int          since_load = -1;
  bit [WB-1:0] rb [NL];

  always @(posedge clk) begin
    seen_edge = 1;
    if (rst) begin
      m_ph = 0;
      since_rst = 0;
      foreach (m_word[l]) m_word[l] = '0;
    end else begin
      if (m_ph == WB-1)
        foreach (m_word[l]) m_word[l] = word_i[l*WB +: WB];
      m_ph = (m_ph + 1) % WB;
      since_rst++;
    end
  end

  // Compare on every falling edge.
  always @(negedge clk) begin
    if (seen_edge) begin
      string tag;
      bit exp_f, exp_l;
      bit [NL-1:0] exp_s;
      tag   = (rst || since_rst < WB) ? "R7" : "R3";
      exp_f = (m_ph == 0) || (m_ph >= 4);
      check(fclk_o == {NG{exp_f}}, tag, "fclk R5", fclk_o, {NG{exp_f}});
      exp_l = (m_ph == WB-1);
      check(load_o == exp_l, (tag == "R7") ? "R7" : "R2", "load", load_o, exp_l);
      for (int l = 0; l < NL; l++) exp_s[l] = m_word[l][WB-1-m_ph];
      check(ser_o == exp_s, (tag == "R7") ? "R7" : "R4", "ser R5", ser_o, exp_s);
      // R1: strobe spacing
      if (load_o) begin
        if (since_load >= 0) check(since_load == WB, "R1", "strobe period", since_load, WB);
        since_load = 0;
      end
      if (since_load >= 0) since_load++;
      if (rst) since_load = -1;
      // R4, R6: rebuilt words match the word present at the strobe edge
      for (int l = 0; l < NL; l++) rb[l] = {rb[l][WB-2:0], ser_o[l]};
      if (!rst && m_ph == WB-1 && since_rst >= WB)
        for (int l = 0; l < NL; l++)
          check(rb[l] == m_word[l], "R4,R6", $sformatf("rebuild lane %0d", l), rb[l], m_word[l]);
    end
  end

  function automatic logic [NL*WB-1:0] rand_word();
    logic [95:0] t;
    t = {$urandom, $urandom, $urandom};
    return t[NL*WB-1:0];
  endfunction

  function automatic logic [NL*WB-1:0] pattern(input int n);
    logic [NL*WB-1:0] w;
    case (n % 6)
      0: w = '0;
      1: w = '1;
      2: for (int b = 0; b < NL*WB; b++) w[b] = b[0];
      3: begin w = '0; w[(n * 5) % (NL*WB)] = 1'b1; end
      4: for (int l = 0; l < NL; l++) w[l*WB +: WB] = WB'(l + 1); // R5 lane-distinct
      default: w = rand_word();
    endcase
    return w;
  endfunction

  initial begin
    int words = 0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < 700; cyc++) begin
      @(negedge clk);
      // R6: junk except in the strobe cycle
      if (m_ph == WB-1) begin word_i = pattern(words); words++; end
      else word_i = rand_word();
      if (cyc == 333) rst = 1'b1;          // R7: reset mid-word
      if (cyc == 336) rst = 1'b0;
    end
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule